// File: doc/BRIEF.md
# Interrupt Controller Command Port Sequencer

This block sits in front of the priority resolver of an eight-line programmable interrupt controller. It decodes byte writes arriving on a two-location register port (address bit 0 selects the location). A write to location 0 with the initialisation bit set starts a setup sequence of up to four bytes. The sequencer takes the follow-on bytes at location 1, and whether it asks for the cascade byte and the mode byte depends on two flags latched from the first byte. Once the sequence is done, location 1 writes load the line mask. Location 0 writes then carry either a status command or a priority command.

Status commands arm a poll, select which register a location-0 read returns, and switch the special-mask mode. Priority commands set the rotate-on-automatic-end flag or send a one-clock command strobe to the resolver: end-of-interrupt variants, set-priority and specific rotate. Reads return the request, in-service or mask register. A read taken while a poll is armed instead returns the resolver's winning line and tells the resolver to clear that line. The priority computation itself lies outside this block. The winning line arrives as an input.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset, `imr`, `vec_base`, `aeoi`, `sfnm`, `smm`, `rd_isr_sel`, `rot_aeoi`, `poll_armed`, `init_clr`, `cmd_stb` and `poll_clr` are all 0, and the sequencer is idle, so that an address-1 write loads `imr`.
- R2: A write to address 0 with bit 4 = 1 clears `imr`, `vec_base` and all mode flags, disarms poll, and pulses `init_clr` for exactly the next clock. It latches bit 0 (mode byte wanted) and bit 1 (single controller, no cascade byte).
- R3: In a single controller that wants a mode byte, the first address-1 byte after initialisation sets `vec_base` to the data with bits 2:0 cleared. The second address-1 byte is then taken as the mode byte.
- R4: In a single controller without a mode byte, the sequencer returns to idle after the base byte, so the next address-1 write loads `imr`.
- R5: In a cascaded controller (bit 1 = 0), the byte after the base byte is accepted as the cascade byte and changes no output. The sequencer then takes the mode byte if bit 0 was 1, or returns to idle otherwise.
- R6: The mode byte sets `sfnm` from bit 4 and `aeoi` from bit 1.
- R7: An address-1 write loads `imr` only when the sequencer is idle. During the setup sequence, `imr` is unchanged.
- R8: An address-0 write with bit 4 = 0 and bit 3 = 1 is a status command. Bit 2 = 1 arms poll. Bit 1 = 1 loads `rd_isr_sel` from bit 0, and bit 1 = 0 leaves it unchanged. Bit 6 = 1 loads `smm` from bit 5, and bit 6 = 0 leaves it unchanged.
- R9: An address-0 write with bits 4 and 3 = 0 is a priority command with code bits 7:5. Codes 0 and 4 set `rot_aeoi` from bit 7 and produce no strobe.
- R10: Priority codes 1, 3, 5, 6 and 7 raise `cmd_stb` for exactly the clock after the write, with `cmd_op` = the code and `cmd_lvl` = bits 2:0. Code 2 produces no strobe and changes nothing.
- R11: A read (with poll disarmed) presents its data on `rdata` from the clock after `rd_en`. Address 0 returns `isr_in` when `rd_isr_sel` = 1 and `irr_in` otherwise. Address 1 returns `imr`.
- R12: A read while poll is armed returns `win_idx` zero-extended when `win_valid` = 1, and pulses `poll_clr` for one clock with `poll_lvl` = `win_idx`. With `win_valid` = 0 it returns 7 and gives no `poll_clr`. Either way, poll is disarmed afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 1 | Register location select |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| wdata | input | 8 | Write data |
| irr_in | input | 8 | Current request register from the resolver |
| isr_in | input | 8 | Current in-service register from the resolver |
| win_valid | input | 1 | Resolver has a winning line |
| win_idx | input | 3 | Index of the winning line |
| rdata | output | 8 | Registered read data |
| imr | output | 8 | Line mask |
| vec_base | output | 8 | Vector base, bits 2:0 always 0 |
| aeoi | output | 1 | Automatic end-of-interrupt mode |
| sfnm | output | 1 | Special fully nested mode |
| smm | output | 1 | Special mask mode |
| rd_isr_sel | output | 1 | Location-0 read returns in-service register |
| rot_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| poll_armed | output | 1 | Poll armed for the next read |
| init_clr | output | 1 | One-clock pulse: resolver clears its state and drops the CPU request |
| cmd_stb | output | 1 | One-clock priority command strobe |
| cmd_op | output | 3 | Priority command code |
| cmd_lvl | output | 3 | Priority command line field |
| poll_clr | output | 1 | One-clock pulse: clear the polled line in request and in-service |
| poll_lvl | output | 3 | Line cleared by the poll |

## Verification
The bench walks all four branches of the setup sequence: single with and without a mode byte, and cascaded with and without one. A sequencer that mixes up the two latched flags would treat the cascade byte as the mode byte, or as a mask load. This shows up as wrong `sfnm`/`aeoi` values or as a mask that changes during setup. It walks every priority code, including the two no-strobe codes for rotate setup and the inert code 2. A decoder that strobes on those codes, or holds the strobe longer than one clock, is caught by the second-cycle check. The status-command enables are tested with their enable bits clear, to catch a design that loads read-select or special-mask unconditionally. The poll read is tested with and without a winner, and a normal read follows it, to catch a poll that never disarms or a missing 7 on an empty poll.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

    localparam int DW = 8;
    localparam int NLINES = 8;
    localparam int LW = $clog2(NLINES);

    // Bit positions in written bytes that the decoder depends on
    localparam int B_INIT    = 4;
    localparam int B_STAT    = 3;
    localparam int B_WANT4   = 0;
    localparam int B_SINGLE  = 1;
    localparam int B_POLL    = 2;
    localparam int B_RSEL_EN = 1;
    localparam int B_RSEL    = 0;
    localparam int B_SMM_EN  = 6;
    localparam int B_SMM     = 5;
    localparam int B_SFNM    = 4;
    localparam int B_AEOI    = 1;
    localparam int BASE_LSB  = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BASE = 2'd1,
        SEQ_CASC = 2'd2,
        SEQ_MODE = 2'd3
    } seq_t;

    typedef struct packed {
        logic          stb;
        logic [2:0]    op;
        logic [LW-1:0] lvl;
    } pcmd_t;

    function automatic seq_t after_base(logic single, logic want4);
        if (!single)    return SEQ_CASC;
        else if (want4) return SEQ_MODE;
        else            return SEQ_IDLE;
    endfunction

    function automatic logic code_strobes(logic [2:0] code);
        return (code == 3'd1) || (code == 3'd3) || (code == 3'd5) ||
               (code == 3'd6) || (code == 3'd7);
    endfunction

endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          init_stb,
    input  logic          wr1,
    input  logic [DW-1:0] wdata,
    output logic          seq_idle,
    output logic [DW-1:0] vec_base,
    output logic          aeoi,
    output logic          sfnm,
    output logic          init_clr
);

    seq_t state_q;
    logic want4_q, single_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_IDLE;
            want4_q  <= 1'b0;
            single_q <= 1'b0;
            vec_base <= '0;
            aeoi     <= 1'b0;
            sfnm     <= 1'b0;
            init_clr <= 1'b0;
        end else begin
            init_clr <= init_stb;
            if (init_stb) begin
                state_q  <= SEQ_BASE;
                want4_q  <= wdata[B_WANT4];
                single_q <= wdata[B_SINGLE];
                vec_base <= '0;
                aeoi     <= 1'b0;
                sfnm     <= 1'b0;
            end else if (wr1) begin
                unique case (state_q)
                    SEQ_BASE: begin
                        vec_base <= {wdata[DW-1:BASE_LSB], {BASE_LSB{1'b0}}};
                        state_q  <= after_base(single_q, want4_q);
                    end
                    SEQ_CASC: state_q <= want4_q ? SEQ_MODE : SEQ_IDLE;
                    SEQ_MODE: begin
                        sfnm    <= wdata[B_SFNM];
                        aeoi    <= wdata[B_AEOI];
                        state_q <= SEQ_IDLE;
                    end
                    default: state_q <= SEQ_IDLE;
                endcase
            end
        end
    end

    assign seq_idle = (state_q == SEQ_IDLE);

    // R2: an initialisation write always lands in the base-byte state
    a_r2_init_to_base: assert property (@(posedge clk) disable iff (rst)
        $past(init_stb) |-> state_q == SEQ_BASE);

    // R2: clear pulse only follows an initialisation write
    a_r2_clr_follows_init: assert property (@(posedge clk) disable iff (rst)
        init_clr |-> $past(init_stb));

    // R6: mode flags move only on a setup write
    a_r6_modes_stable: assert property (@(posedge clk) disable iff (rst)
        !$past(init_stb) && !$past(wr1) |-> $stable(aeoi) && $stable(sfnm));

endmodule

// File: rtl/pic_ocw_dec.sv
module pic_ocw_dec
    import pic_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          init_stb,
    input  logic          stat_stb,
    input  logic          prio_stb,
    input  logic          imr_stb,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] imr,
    output logic          rd_isr_sel,
    output logic          smm,
    output logic          rot_aeoi,
    output logic          poll_arm,
    output pcmd_t         cmd
);

    logic [2:0] code;
    assign code     = wdata[DW-1:DW-3];
    assign poll_arm = stat_stb && wdata[B_POLL];

    always_ff @(posedge clk) begin
        if (rst || init_stb) begin
            imr        <= '0;
            rd_isr_sel <= 1'b0;
            smm        <= 1'b0;
            rot_aeoi   <= 1'b0;
            cmd        <= '0;
        end else begin
            cmd.stb <= 1'b0;
            if (imr_stb) imr <= wdata;
            if (stat_stb) begin
                if (wdata[B_RSEL_EN]) rd_isr_sel <= wdata[B_RSEL];
                if (wdata[B_SMM_EN])  smm        <= wdata[B_SMM];
            end
            if (prio_stb) begin
                if (code[1:0] == 2'b00) rot_aeoi <= code[2];
                if (code_strobes(code)) begin
                    cmd.stb <= 1'b1;
                    cmd.op  <= code;
                    cmd.lvl <= wdata[LW-1:0];
                end
            end
        end
    end

    // R10: a command strobe is always the echo of a priority write
    a_r10_stb_from_prio: assert property (@(posedge clk) disable iff (rst)
        cmd.stb |-> $past(prio_stb));

    // R10: no strobe from the inert or rotate-setup codes
    a_r10_no_stb_inert: assert property (@(posedge clk) disable iff (rst)
        cmd.stb |-> cmd.op != 3'd0 && cmd.op != 3'd2 && cmd.op != 3'd4);

    // R7: mask holds unless loaded or cleared
    a_r7_imr_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(imr_stb) && !$past(init_stb) |-> $stable(imr));

endmodule

// File: rtl/pic_rd_port.sv
module pic_rd_port
    import pic_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          init_stb,
    input  logic          poll_arm,
    input  logic          rd_en,
    input  logic          addr,
    input  logic          rd_isr_sel,
    input  logic [DW-1:0] irr_in,
    input  logic [DW-1:0] isr_in,
    input  logic [DW-1:0] imr,
    input  logic          win_valid,
    input  logic [LW-1:0] win_idx,
    output logic [DW-1:0] rdata,
    output logic          poll_armed,
    output logic          poll_clr,
    output logic [LW-1:0] poll_lvl
);

    localparam logic [DW-1:0] EMPTY_POLL = {{(DW-LW){1'b0}}, {LW{1'b1}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata      <= '0;
            poll_armed <= 1'b0;
            poll_clr   <= 1'b0;
            poll_lvl   <= '0;
        end else begin
            poll_clr <= 1'b0;
            if (init_stb)      poll_armed <= 1'b0;
            else if (poll_arm) poll_armed <= 1'b1;
            else if (rd_en)    poll_armed <= 1'b0;
            if (rd_en) begin
                if (poll_armed) begin
                    rdata    <= win_valid ? {{(DW-LW){1'b0}}, win_idx} : EMPTY_POLL;
                    poll_clr <= win_valid;
                    poll_lvl <= win_idx;
                end else if (addr) begin
                    rdata <= imr;
                end else begin
                    rdata <= rd_isr_sel ? isr_in : irr_in;
                end
            end
        end
    end

    // R12: a poll clear follows only a read taken with poll armed
    a_r12_clr_needs_poll: assert property (@(posedge clk) disable iff (rst)
        poll_clr |-> $past(rd_en) && $past(poll_armed) && $past(win_valid));

    // R12: a polled read disarms poll
    a_r12_disarm: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en) && $past(poll_armed) && !$past(poll_arm) |-> !poll_armed);

endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
    import pic_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [7:0]    wdata,
    input  logic [7:0]    irr_in,
    input  logic [7:0]    isr_in,
    input  logic          win_valid,
    input  logic [2:0]    win_idx,
    output logic [7:0]    rdata,
    output logic [7:0]    imr,
    output logic [7:0]    vec_base,
    output logic          aeoi,
    output logic          sfnm,
    output logic          smm,
    output logic          rd_isr_sel,
    output logic          rot_aeoi,
    output logic          poll_armed,
    output logic          init_clr,
    output logic          cmd_stb,
    output logic [2:0]    cmd_op,
    output logic [2:0]    cmd_lvl,
    output logic          poll_clr,
    output logic [2:0]    poll_lvl
);

    logic  wr0, wr1, init_stb, stat_stb, prio_stb, imr_stb;
    logic  seq_idle, poll_arm;
    pcmd_t cmd;

    assign wr0      = wr_en && !addr;
    assign wr1      = wr_en && addr;
    assign init_stb = wr0 && wdata[B_INIT];
    assign stat_stb = wr0 && !wdata[B_INIT] && wdata[B_STAT];
    assign prio_stb = wr0 && !wdata[B_INIT] && !wdata[B_STAT];
    assign imr_stb  = wr1 && seq_idle;

    pic_init_seq u_init (
        .clk      (clk),
        .rst      (rst),
        .init_stb (init_stb),
        .wr1      (wr1),
        .wdata    (wdata),
        .seq_idle (seq_idle),
        .vec_base (vec_base),
        .aeoi     (aeoi),
        .sfnm     (sfnm),
        .init_clr (init_clr)
    );

    pic_ocw_dec u_ocw (
        .clk        (clk),
        .rst        (rst),
        .init_stb   (init_stb),
        .stat_stb   (stat_stb),
        .prio_stb   (prio_stb),
        .imr_stb    (imr_stb),
        .wdata      (wdata),
        .imr        (imr),
        .rd_isr_sel (rd_isr_sel),
        .smm        (smm),
        .rot_aeoi   (rot_aeoi),
        .poll_arm   (poll_arm),
        .cmd        (cmd)
    );

    pic_rd_port u_rd (
        .clk        (clk),
        .rst        (rst),
        .init_stb   (init_stb),
        .poll_arm   (poll_arm),
        .rd_en      (rd_en),
        .addr       (addr),
        .rd_isr_sel (rd_isr_sel),
        .irr_in     (irr_in),
        .isr_in     (isr_in),
        .imr        (imr),
        .win_valid  (win_valid),
        .win_idx    (win_idx),
        .rdata      (rdata),
        .poll_armed (poll_armed),
        .poll_clr   (poll_clr),
        .poll_lvl   (poll_lvl)
    );

    assign cmd_stb = cmd.stb;
    assign cmd_op  = cmd.op;
    assign cmd_lvl = cmd.lvl;

    // R3: vector base low bits never set
    a_r3_base_aligned: assert property (@(posedge clk) disable iff (rst)
        $past(wr1) |-> vec_base[2:0] == 3'b000);

endmodule

// File: tb/pic_cmd_seq_tb_top.sv
module pic_cmd_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, irr_in = '0, isr_in = '0;
    logic       win_valid = 1'b0;
    logic [2:0] win_idx = '0;
    logic [7:0] rdata, imr, vec_base;
    logic       aeoi, sfnm, smm, rd_isr_sel, rot_aeoi, poll_armed, init_clr;
    logic       cmd_stb, poll_clr;
    logic [2:0] cmd_op, cmd_lvl, poll_lvl;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    pic_cmd_seq dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .irr_in(irr_in), .isr_in(isr_in),
        .win_valid(win_valid), .win_idx(win_idx), .rdata(rdata), .imr(imr),
        .vec_base(vec_base), .aeoi(aeoi), .sfnm(sfnm), .smm(smm),
        .rd_isr_sel(rd_isr_sel), .rot_aeoi(rot_aeoi), .poll_armed(poll_armed),
        .init_clr(init_clr), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
        .cmd_lvl(cmd_lvl), .poll_clr(poll_clr), .poll_lvl(poll_lvl)
    );

    // {data, stb, op, lvl, rot_aeoi} for priority-command writes (R9, R10)
    localparam int NV = 9;
    localparam logic [15:0] VEC [NV] = '{
        {8'h80, 1'b0, 3'd0, 3'd0, 1'b1},
        {8'h20, 1'b1, 3'd1, 3'd0, 1'b1},
        {8'h00, 1'b0, 3'd0, 3'd0, 1'b0},
        {8'h63, 1'b1, 3'd3, 3'd3, 1'b0},
        {8'hA0, 1'b1, 3'd5, 3'd0, 1'b0},
        {8'hC6, 1'b1, 3'd6, 3'd6, 1'b0},
        {8'hE2, 1'b1, 3'd7, 3'd2, 1'b0},
        {8'h45, 1'b0, 3'd0, 3'd0, 1'b0},
        {8'h84, 1'b0, 3'd0, 3'd0, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; outputs are sampled at the next falling edge
    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 imr", imr, 8'h00);
        chk("R1 vec", vec_base, 8'h00);
        chk("R1 flags", {aeoi, sfnm, smm, rd_isr_sel, rot_aeoi, poll_armed, init_clr, cmd_stb}, 8'h00);
        chk("R1 poll_clr", {7'd0, poll_clr}, 8'h00);
        wr(1'b1, 8'h5A);
        chk("R1 R7 idle loads imr", imr, 8'h5A);
        rd(1'b1);
        chk("R11 read imr", rdata, 8'h5A);

        // cascaded, mode byte wanted
        wr(1'b0, 8'h11);
        chk("R2 init_clr pulse", {7'd0, init_clr}, 8'h01);
        chk("R2 imr cleared", imr, 8'h00);
        @(negedge clk);
        chk("R2 init_clr one clock", {7'd0, init_clr}, 8'h00);
        wr(1'b1, 8'h47);
        chk("R3 base masked", vec_base, 8'h40);
        chk("R7 no imr in setup", imr, 8'h00);
        wr(1'b1, 8'h04);
        chk("R5 cascade byte inert", {imr[6:0], aeoi}, 8'h00);
        chk("R5 cascade keeps base", vec_base, 8'h40);
        wr(1'b1, 8'h12);
        chk("R6 sfnm aeoi", {6'd0, sfnm, aeoi}, 8'h03);
        wr(1'b1, 8'h33);
        chk("R5 idle after mode", imr, 8'h33);

        // cascaded, no mode byte
        wr(1'b0, 8'h10);
        chk("R2 modes cleared", {6'd0, sfnm, aeoi}, 8'h00);
        chk("R2 vec cleared", vec_base, 8'h00);
        wr(1'b1, 8'h88);
        chk("R5 base", vec_base, 8'h88);
        wr(1'b1, 8'h02);
        chk("R5 cascade no imr", imr, 8'h00);
        wr(1'b1, 8'h0F);
        chk("R5 idle after cascade", imr, 8'h0F);
        chk("R5 no mode applied", {6'd0, sfnm, aeoi}, 8'h00);

        // single, no mode byte
        wr(1'b0, 8'h12);
        wr(1'b1, 8'h20);
        chk("R4 base", vec_base, 8'h20);
        wr(1'b1, 8'h0A);
        chk("R4 idle after base", imr, 8'h0A);

        // single, mode byte wanted
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h08);
        chk("R3 base", vec_base, 8'h08);
        wr(1'b1, 8'h02);
        chk("R3 mode byte taken", {6'd0, sfnm, aeoi}, 8'h01);
        chk("R7 mode byte not imr", imr, 8'h00);
        wr(1'b1, 8'h55);
        chk("R3 idle after mode", imr, 8'h55);

        // status commands
        irr_in = 8'hA5; isr_in = 8'h3C;
        rd(1'b0);
        chk("R11 read irr", rdata, 8'hA5);
        wr(1'b0, 8'h0B);
        chk("R8 rsel set", {7'd0, rd_isr_sel}, 8'h01);
        rd(1'b0);
        chk("R11 read isr", rdata, 8'h3C);
        wr(1'b0, 8'h0A);
        chk("R8 rsel clear", {7'd0, rd_isr_sel}, 8'h00);
        wr(1'b0, 8'h09);
        chk("R8 rsel enable off", {7'd0, rd_isr_sel}, 8'h00);
        wr(1'b0, 8'h68);
        chk("R8 smm set", {7'd0, smm}, 8'h01);
        wr(1'b0, 8'h28);
        chk("R8 smm enable off", {7'd0, smm}, 8'h01);
        wr(1'b0, 8'h48);
        chk("R8 smm clear", {7'd0, smm}, 8'h00);

        // poll with a winner
        wr(1'b0, 8'h0C);
        chk("R8 poll armed", {7'd0, poll_armed}, 8'h01);
        win_valid = 1'b1; win_idx = 3'd5;
        rd(1'b0);
        chk("R12 poll data", rdata, 8'h05);
        chk("R12 poll_clr", {7'd0, poll_clr}, 8'h01);
        chk("R12 poll_lvl", {5'd0, poll_lvl}, 8'h05);
        chk("R12 disarmed", {7'd0, poll_armed}, 8'h00);
        @(negedge clk);
        chk("R12 poll_clr one clock", {7'd0, poll_clr}, 8'h00);
        rd(1'b0);
        chk("R12 normal read after poll", rdata, 8'hA5);
        // poll with no winner
        wr(1'b0, 8'h0C);
        win_valid = 1'b0;
        rd(1'b0);
        chk("R12 empty poll", rdata, 8'h07);
        chk("R12 empty no clr", {7'd0, poll_clr}, 8'h00);

        // priority command table
        for (int i = 0; i < NV; i++) begin
            wr(1'b0, VEC[i][15:8]);
            chk("R9 rot_aeoi", {7'd0, rot_aeoi}, {7'd0, VEC[i][0]});
            chk("R10 stb", {7'd0, cmd_stb}, {7'd0, VEC[i][7]});
            if (VEC[i][7])
                chk("R10 op lvl", {2'd0, cmd_op, cmd_lvl}, {2'd0, VEC[i][6:1]});
            @(negedge clk);
            chk("R10 stb one clock", {7'd0, cmd_stb}, 8'h00);
        end
        chk("R10 imr untouched", imr, 8'h55);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule